// File: doc/BRIEF.md
# Multi-Format Audio Serial Receive Port

This block receives serial audio sample data for a multichannel DAC. It works on a fast system clock and oversamples a serial bit clock, a frame clock and up to four serial data lines. It turns the stream into 24-bit parallel sample words. Four framings can be selected: I2S, left-justified, right-justified, and a 16-slot TDM mode that runs on a single data line. In the stereo framings each data line carries one stereo pair, and all lines share the bit clock and the frame clock.

The port works as clock slave, following bit and frame clocks supplied from outside. It can also work as clock master. In master mode it divides the system clock to produce the bit clock and the frame clock on its own outputs, and it receives against those generated clocks. Every completed word is presented for exactly one system clock with a channel index. In the stereo framings the words that finish together on several lines leave one after another, in ascending line order.

Top module: `tdm_rx_port`

## Requirements
- R1: While and after reset, word_valid, bclk_out and fclk_out are low.
- R2: With fmt = 0 (I2S), the frame clock low marks the left channel (side 0) and the MSB arrives one bit clock after the frame clock edge. A word on line L is reported with channel index 2·L + side.
- R3: With fmt = 1 (left-justified), the frame clock high marks the left channel (side 0) and the MSB is the first bit after the frame clock edge. The channel index is 2·L + side.
- R4: With fmt = 2 (right-justified), each half frame is 32 bit clocks, the frame clock high marks the left channel, and the word occupies the last 24 bits of the half. The channel index is 2·L + side.
- R5: With fmt = 3 (TDM), a one-bit-wide high frame pulse marks bit 0 of slot 0. Each of the 16 slots is 32 bits wide and holds a 24-bit word MSB first in its first 24 bits. Only line 0 is read, and the channel index equals the slot number.
- R6: In the stereo framings all four lines are received. Words that complete on the same bit are reported on consecutive clocks in ascending line order.
- R7: No word is reported until a frame boundary has been seen after reset or after any change of fmt or master_en.
- R8: With master_en = 1, bclk_out has a period of 2·HALF_DIV system clocks. In the stereo framings fclk_out is high for 32 bit clocks and low for 32 bit clocks. In TDM it is a pulse one bit clock wide, once every 512 bit clocks. Reception then uses these generated clocks.
- R9: With master_en = 0, bclk_out and fclk_out stay low.
- R10: Every word is reported by a word_valid pulse one system clock wide. A TDM frame yields exactly 16 words.
- R11: Bits outside the 24 data positions of a half frame or slot do not change any reported word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: generate the serial clocks; 0: follow external clocks |
| fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fclk_in | input | 1 | External frame clock or frame pulse (slave mode) |
| sdata_in | input | 4 | Serial data lines, one per stereo pair; line 0 in TDM |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| fclk_out | output | 1 | Generated frame clock or frame pulse (master mode) |
| word_valid | output | 1 | One-clock strobe for a completed word |
| word_data | output | 24 | Received sample word |
| word_chan | output | 4 | Channel index of the word |

## Verification
The serial inputs pass two synchroniser stages and one edge stage. A word's line 0 result is therefore registered on word_valid four system clocks after the rising bit clock that carries its last bit is first sampled. Lines 1 to 3 follow on the next three clocks. The bench drives each bit for eight system clocks and sets it on the falling system edge. It collects every strobe in a monitor, and it compares the collected words only after waiting 40 clocks past the last bit, which covers both the pipeline and the drain. The master-mode clock periods are measured in whole system cycles between edges of the generated outputs.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

endpackage

// File: rtl/tdm_rx_clkgen.sv
module tdm_rx_clkgen #(
  parameter int HALF_DIV = 4,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tdm,
  output logic bclk,
  output logic fclk
);

  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int SB    = $clog2(SLOT_W);
  localparam int POS_W = $clog2(SLOT_W * SLOTS);

  logic [DIV_W-1:0] div_q, div_d;
  logic             bclk_q, bclk_d;
  logic [POS_W-1:0] bit_q, bit_d;
  logic             tick;

  always_comb begin
    tick   = (div_q == DIV_W'(HALF_DIV - 1));
    div_d  = div_q;
    bclk_d = bclk_q;
    bit_d  = bit_q;
    if (!en) begin
      div_d  = '0;
      bclk_d = 1'b0;
      bit_d  = POS_W'(1);
    end else if (tick) begin
      div_d  = '0;
      bclk_d = ~bclk_q;
      if (bclk_q) begin
        bit_d = bit_q + 1'b1;
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
      bit_q  <= POS_W'(1);
    end else begin
      div_q  <= div_d;
      bclk_q <= bclk_d;
      bit_q  <= bit_d;
    end
  end

  assign bclk = bclk_q;
  assign fclk = tdm ? (bit_q == '0) : bit_q[SB];

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bclk_q);

endmodule

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  assign dout = s2_q;

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_now
);

  logic [WORD_W-2:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) begin
      sh_d = {sh_q[WORD_W-3:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign word_now = {sh_q, bit_in};

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 16,
  localparam int SIW   = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_stb,
  input  logic           frm_lvl,
  input  fmt_e           fmt,
  input  logic           mode_chg,
  output logic           emit,
  output logic           side,
  output logic [SIW-1:0] slot
);

  localparam int SB    = $clog2(SLOT_W);
  localparam int POS_W = $clog2(SLOT_W * SLOTS);

  logic [POS_W-1:0] pos_q, pos_d, pos_now, limit;
  logic             prev_q, prev_d;
  logic             lock_q, lock_d, lock_now;
  logic             is_tdm, boundary, hit;
  logic [SB-1:0]    last;

  always_comb begin
    is_tdm   = (fmt == FMT_TDM);
    boundary = is_tdm ? (frm_lvl & ~prev_q) : (frm_lvl ^ prev_q);
    limit    = is_tdm ? POS_W'(SLOT_W * SLOTS - 1) : POS_W'(SLOT_W);
    if (boundary) begin
      pos_now = '0;
    end else if (pos_q >= limit) begin
      pos_now = limit;
    end else begin
      pos_now = pos_q + 1'b1;
    end
    case (fmt)
      FMT_I2S: last = SB'(WORD_W);
      FMT_RJ:  last = SB'(SLOT_W - 1);
      default: last = SB'(WORD_W - 1);
    endcase
    lock_now = (boundary | lock_q) & ~mode_chg;
    hit      = (pos_now[SB-1:0] == last) &&
               (is_tdm || (pos_now[POS_W-1:SB] == '0));
    emit     = bit_stb & lock_now & hit;
    side     = (fmt == FMT_I2S) ? frm_lvl : ~frm_lvl;
    slot     = pos_now[POS_W-1:SB];

    pos_d  = pos_q;
    prev_d = prev_q;
    lock_d = lock_q;
    if (bit_stb) begin
      pos_d  = pos_now;
      prev_d = frm_lvl;
      lock_d = lock_now;
    end
    if (mode_chg) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      prev_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      prev_q <= prev_d;
      lock_q <= lock_d;
    end
  end

  // R7
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !lock_q);

endmodule

// File: rtl/tdm_rx_port.sv
module tdm_rx_port
  import tdm_rx_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 16,
  parameter int NLINES   = 4,
  parameter int HALF_DIV = 4,
  localparam int CHAN_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic [1:0]        fmt,
  input  logic              bclk_in,
  input  logic              fclk_in,
  input  logic [NLINES-1:0] sdata_in,
  output logic              bclk_out,
  output logic              fclk_out,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [CHAN_W-1:0] word_chan
);

  localparam int LINE_W = $clog2(NLINES);
  localparam int SYN_W  = NLINES + 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_ni = rs_q[1];

  // clock generation for master mode
  fmt_e fmt_cur;
  logic gen_bclk, gen_fclk;

  assign fmt_cur = fmt_e'(fmt);

  tdm_rx_clkgen #(
    .HALF_DIV(HALF_DIV),
    .SLOT_W  (SLOT_W),
    .SLOTS   (SLOTS)
  ) u_clkgen (
    .clk  (clk),
    .rst_n(rst_ni),
    .en   (master_en),
    .tdm  (fmt_cur == FMT_TDM),
    .bclk (gen_bclk),
    .fclk (gen_fclk)
  );

  assign bclk_out = gen_bclk;
  assign fclk_out = gen_fclk;

  // serial inputs into the system clock domain
  logic             bclk_src, fclk_src;
  logic [SYN_W-1:0] syn_out;
  logic             b_s, f_s, bd_q, bit_stb;
  logic [NLINES-1:0] d_s;

  assign bclk_src = master_en ? gen_bclk : bclk_in;
  assign fclk_src = master_en ? gen_fclk : fclk_in;

  tdm_rx_sync #(.W(SYN_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_ni),
    .din  ({fclk_src, bclk_src, sdata_in}),
    .dout (syn_out)
  );

  assign f_s     = syn_out[SYN_W-1];
  assign b_s     = syn_out[SYN_W-2];
  assign d_s     = syn_out[NLINES-1:0];
  assign bit_stb = b_s & ~bd_q;

  // mode tracking
  logic [1:0] fmt_q;
  logic       mst_q, mode_chg;

  assign mode_chg = (fmt != fmt_q) | (master_en != mst_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bd_q  <= 1'b0;
      fmt_q <= 2'd0;
      mst_q <= 1'b0;
    end else begin
      bd_q  <= b_s;
      fmt_q <= fmt;
      mst_q <= master_en;
    end
  end

  // frame position tracking
  logic              emit, emit_side;
  logic [CHAN_W-1:0] emit_slot;

  tdm_rx_framer #(
    .WORD_W(WORD_W),
    .SLOT_W(SLOT_W),
    .SLOTS (SLOTS)
  ) u_framer (
    .clk     (clk),
    .rst_n   (rst_ni),
    .bit_stb (bit_stb),
    .frm_lvl (f_s),
    .fmt     (fmt_cur),
    .mode_chg(mode_chg),
    .emit    (emit),
    .side    (emit_side),
    .slot    (emit_slot)
  );

  // per-line shift registers
  logic [WORD_W-1:0] lane_word [NLINES];

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_lane
    tdm_rx_lane #(.WORD_W(WORD_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_ni),
      .shift_en(bit_stb),
      .bit_in  (d_s[gi]),
      .word_now(lane_word[gi])
    );
  end

  // word hold and sequential drain
  logic [WORD_W-1:0] hold_q [NLINES];
  logic [WORD_W-1:0] hold_d [NLINES];
  logic [NLINES-1:0] pend_q, pend_d;
  logic              side_q, side_d, tdm_q, tdm_d;
  logic [CHAN_W-1:0] slot_q, slot_d;
  logic [LINE_W-1:0] pick;
  logic              found;
  logic              vld_d;
  logic [WORD_W-1:0] data_d;
  logic [CHAN_W-1:0] chan_d;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NLINES; i++) begin
      if (pend_q[i] && !found) begin
        pick  = LINE_W'(i);
        found = 1'b1;
      end
    end

    vld_d  = found;
    data_d = hold_q[pick];
    chan_d = tdm_q ? slot_q : CHAN_W'({pick, side_q});

    pend_d = pend_q;
    if (found) begin
      pend_d[pick] = 1'b0;
    end
    side_d = side_q;
    slot_d = slot_q;
    tdm_d  = tdm_q;
    for (int i = 0; i < NLINES; i++) begin
      hold_d[i] = hold_q[i];
    end
    if (emit) begin
      side_d = emit_side;
      slot_d = emit_slot;
      tdm_d  = (fmt_cur == FMT_TDM);
      if (fmt_cur == FMT_TDM) begin
        pend_d    = NLINES'(1);
        hold_d[0] = lane_word[0];
      end else begin
        pend_d = '1;
        for (int i = 0; i < NLINES; i++) begin
          hold_d[i] = lane_word[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      side_q     <= 1'b0;
      slot_q     <= '0;
      tdm_q      <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_chan  <= '0;
      for (int i = 0; i < NLINES; i++) begin
        hold_q[i] <= '0;
      end
    end else begin
      pend_q     <= pend_d;
      side_q     <= side_d;
      slot_q     <= slot_d;
      tdm_q      <= tdm_d;
      word_valid <= vld_d;
      word_data  <= data_d;
      word_chan  <= chan_d;
      for (int i = 0; i < NLINES; i++) begin
        hold_q[i] <= hold_d[i];
      end
    end
  end

  // R10
  tdm_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (word_valid && fmt == 2'd3) |=> !word_valid);

  // R6
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (word_valid && fmt != 2'd3 && word_chan[LINE_W:1] != LINE_W'(NLINES - 1))
    |=> (word_valid && word_chan[LINE_W:1] == $past(word_chan[LINE_W:1]) + 1'b1));

  // R2
  stereo_chan_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (word_valid && fmt != 2'd3) |-> (word_chan < CHAN_W'(2 * NLINES)));

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!master_en && !mst_q) |-> (!bclk_out && !fclk_out));

endmodule

// File: tb/tdm_rx_port_tb.sv
module tdm_rx_port_tb_top;

  logic        clk;
  logic        rst_n;
  logic        master_en;
  logic [1:0]  fmt;
  logic        bclk_in;
  logic        fclk_in;
  logic [3:0]  sdata_in;
  logic        bclk_out;
  logic        fclk_out;
  logic        word_valid;
  logic [23:0] word_data;
  logic [3:0]  word_chan;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;
  logic [27:0] exp_q [$];
  logic [27:0] got_q [$];

  tdm_rx_port dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .fmt       (fmt),
    .bclk_in   (bclk_in),
    .fclk_in   (fclk_in),
    .sdata_in  (sdata_in),
    .bclk_out  (bclk_out),
    .fclk_out  (fclk_out),
    .word_valid(word_valid),
    .word_data (word_data),
    .word_chan (word_chan)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && word_valid) got_q.push_back({word_chan, word_data});
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // position of a data bit inside a 32-bit half frame, -1 when padding
  function automatic int data_idx(input int f, input int b);
    case (f)
      0:       return (b >= 1 && b <= 24) ? 24 - b : -1;
      1:       return (b < 24) ? 23 - b : -1;
      default: return (b >= 8) ? 31 - b : -1;
    endcase
  endfunction

  task automatic put_bit(input logic lv, input logic [3:0] d);
    @(negedge clk);
    bclk_in  = 1'b0;
    fclk_in  = lv;
    sdata_in = d;
    repeat (4) @(negedge clk);
    bclk_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_words(input string req);
    repeat (40) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, "word count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, "chan/data", got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic do_reset(input logic m, input logic [1:0] f);
    @(negedge clk);
    rst_n     = 1'b0;
    master_en = m;
    fmt       = f;
    bclk_in   = 1'b0;
    fclk_in   = 1'b0;
    sdata_in  = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic send_stereo(input int f);
    logic [23:0] w [4][2];
    logic        left_lv;
    logic        lv;
    logic [3:0]  d;
    int          idx;
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 2; s++) w[l][s] = 24'($urandom);
    left_lv = (f == 0) ? 1'b0 : 1'b1;
    put_bit(~left_lv, 4'($urandom));
    for (int h = 0; h < 2; h++) begin
      lv = (h == 0) ? left_lv : ~left_lv;
      for (int b = 0; b < 32; b++) begin
        idx = data_idx(f, b);
        for (int l = 0; l < 4; l++)
          d[l] = (idx >= 0) ? w[l][h][idx] : 1'($urandom);
        put_bit(lv, d);
      end
    end
    for (int h = 0; h < 2; h++)
      for (int l = 0; l < 4; l++) exp_q.push_back({4'(l * 2 + h), w[l][h]});
  endtask

  task automatic send_tdm();
    logic [23:0] w [16];
    logic [3:0]  d;
    for (int s = 0; s < 16; s++) w[s] = 24'($urandom);
    put_bit(1'b0, 4'($urandom));
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 32; b++) begin
        d    = 4'($urandom);
        d[0] = (b < 24) ? w[s][23 - b] : 1'($urandom);
        put_bit((s == 0 && b == 0), d);
      end
    end
    for (int s = 0; s < 16; s++) exp_q.push_back({4'(s), w[s]});
  endtask

  initial begin
    int c0;
    logic [23:0] mw [4][2];
    int bitn;
    void'($urandom(32'h5eed_a11d));
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    master_en = 1'b0;
    fmt       = 2'd1;
    bclk_in   = 1'b0;
    fclk_in   = 1'b0;
    sdata_in  = 4'h0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b0, "R1", "word_valid in reset", word_valid, 0);
    do_reset(1'b0, 2'd1);
    chk(word_valid == 1'b0, "R1", "word_valid after reset", word_valid, 0);
    chk(bclk_out == 1'b0, "R1", "bclk_out after reset", bclk_out, 0);
    chk(fclk_out == 1'b0, "R1", "fclk_out after reset", fclk_out, 0);

    // R7: no frame boundary yet, steady frame clock -> no words
    for (int i = 0; i < 40; i++) put_bit(1'b0, 4'($urandom));
    compare_words("R7");

    // R3 left-justified, R6 four lines, R11 random padding
    for (int k = 0; k < 2; k++) begin
      send_stereo(1);
      compare_words("R3");
    end
    // R9 quiet master outputs in slave mode
    chk(bclk_out == 1'b0 && fclk_out == 1'b0, "R9", "clock outputs in slave",
        {bclk_out, fclk_out}, 0);

    // R2 I2S
    fmt = 2'd0;
    for (int k = 0; k < 2; k++) begin
      send_stereo(0);
      compare_words("R2");
    end

    // R4 right-justified (also R11: padding ahead of the word)
    fmt = 2'd2;
    for (int k = 0; k < 2; k++) begin
      send_stereo(2);
      compare_words("R4");
    end

    // R7 mode change drops lock: TDM without a frame pulse -> no words
    @(negedge clk);
    fmt = 2'd3;
    for (int i = 0; i < 60; i++) put_bit(1'b0, 4'($urandom));
    compare_words("R7");

    // R5 TDM, R10 exactly 16 words
    for (int k = 0; k < 2; k++) begin
      send_tdm();
      compare_words("R5");
    end

    // R8 master mode, left-justified
    do_reset(1'b1, 2'd1);
    @(posedge bclk_out); c0 = cyc;
    @(posedge bclk_out);
    chk(cyc - c0 == 8, "R8", "bclk_out period", cyc - c0, 8);
    @(posedge fclk_out); c0 = cyc;
    @(negedge fclk_out);
    chk(cyc - c0 == 256, "R8", "fclk_out high time", cyc - c0, 256);
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 2; s++) mw[l][s] = 24'($urandom);
    @(posedge fclk_out);
    got_q.delete();
    for (int b = 0; b < 64; b++) begin
      if (b > 0) @(negedge bclk_out);
      @(negedge clk);
      bitn = b % 32;
      for (int l = 0; l < 4; l++)
        sdata_in[l] = (bitn < 24) ? mw[l][b / 32][23 - bitn] : 1'($urandom);
    end
    @(posedge bclk_out);
    for (int h = 0; h < 2; h++)
      for (int l = 0; l < 4; l++) exp_q.push_back({4'(l * 2 + h), mw[l][h]});
    compare_words("R8");

    // R8 master mode, TDM frame pulse
    do_reset(1'b1, 2'd3);
    @(posedge fclk_out); c0 = cyc;
    @(negedge fclk_out);
    chk(cyc - c0 == 8, "R8", "TDM pulse width", cyc - c0, 8);
    @(posedge fclk_out);
    chk(cyc - c0 == 4096, "R8", "TDM frame period", cyc - c0, 4096);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule